// File: doc/BRIEF.md
# Self-Timed Memory Slave for an Interlocked Execution Bus

This block is the responding side of a two-strobe execution bus, placed in front of a small local memory. A master puts a 24-bit byte address on the bus with an address strobe, then raises a data strobe. The slave checks whether the address falls inside its own window, a power-of-two range set by parameters. If it does, the slave carries out the access and raises acknowledge only when the access is really done. A parameterised wait count sets the slave's own access time.

Acknowledge means two different things. On a write it means the selected bytes are stored in the array. On a read it means the read word is already driven on the data output, with the output enable raised. Acknowledge and the output enable stay high until the master drops both strobes. This closes the four-phase interlock. Accesses outside the window get no response at all.

The bus carries 16-bit words on two byte lanes. Bit 0 of the address and a byte-high-enable input select which lanes a write touches. This allows 8-bit accesses to either lane and full 16-bit accesses.

Top module: `xbus_mem_slave`

## Requirements
- R1: After reset, `ack` and `rd_oe` are low, and every word of the array reads as zero.
- R2: The slave responds only if `addr[23:WB]` equals `BASE_ADDR[23:WB]`, where WB = log2(WIN_BYTES). For any other address, `ack` and `rd_oe` stay low for the whole strobe period.
- R3: On a write hit, `ack` first reads high after the (WAIT_CLKS+2)-th rising edge that follows `data_stb` being driven high, one clock after the address cycle.
- R4: On a read hit, `rd_oe` is high and `rdata` holds the addressed word one clock before `ack` first reads high, which is after the (WAIT_CLKS+3)-th such edge. `ack` is never high on a read without `rd_oe`.
- R5: Write data is captured on the first clock edge that sees `data_stb` high. Later changes on `wdata` do not affect what is stored.
- R6: The word index is `addr[WB-1:1]`. A write stores `wdata[7:0]` into the low byte only when `addr[0]` is 0. It stores `wdata[15:8]` into the high byte only when `byte_hi` is 1. A read returns the low byte on `rdata[7:0]` and the high byte on `rdata[15:8]`.
- R7: `ack` and `rd_oe` fall after the first rising edge at which `addr_stb` and `data_stb` are both low.
- R8: `rd_oe` is never high during a write access.
- R9: Once high, `ack` stays high while either strobe is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | Address valid strobe from the master |
| addr | input | 24 | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| byte_hi | input | 1 | Upper byte lane enable |
| data_stb | input | 1 | Data valid strobe from the master |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when not driven |
| rd_oe | output | 1 | Read data output enable |
| ack | output | 1 | Transfer acknowledge |

## Verification
Every hit takes the same path. The address is taken on the first edge after `addr_stb` rises, and `data_stb` is driven one clock later. From that point, a write acknowledges after WAIT_CLKS+2 edges and a read after WAIT_CLKS+3 edges, with the output enable one edge earlier. The bench counts rising edges from the clock in which it drives `data_stb` and samples on the falling edge. It demands the exact count, confirms that `rd_oe` came first on reads, and compares `rdata` with a byte-lane model. Release is checked one edge after both strobes drop. Misses are watched for several cycles beyond the longest hit latency.

// File: rtl/xbus_mem_slave.sv
module xbus_mem_slave #(
  parameter logic [23:0] BASE_ADDR = 24'h040000,
  parameter int WIN_BYTES = 256,
  parameter int WAIT_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_stb,
  input  logic [23:0] addr,
  input  logic        wr,
  input  logic        byte_hi,
  input  logic        data_stb,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rd_oe,
  output logic        ack
);
  localparam int WB = $clog2(WIN_BYTES);
  localparam int WORDS = WIN_BYTES / 2;
  localparam int IW = WB - 1;
  localparam int CW = $clog2(WAIT_CLKS + 2);

  typedef enum logic [2:0] {S_IDLE, S_DSWAIT, S_BUSY, S_DRIVE, S_ACK, S_MISS} st_t;

  st_t           st;
  logic          wr_q, lo_q, hi_q;
  logic [IW-1:0] idx_q;
  logic [15:0]   wd_q, rd_q;
  logic [CW-1:0] cnt;
  logic [15:0]   mem [WORDS];

  wire hit = addr[23:WB] == BASE_ADDR[23:WB];

  assign rdata = rd_oe ? rd_q : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wr_q  <= 1'b0;
      lo_q  <= 1'b0;
      hi_q  <= 1'b0;
      idx_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      cnt   <= '0;
      ack   <= 1'b0;
      rd_oe <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (addr_stb) begin
          wr_q  <= wr;
          lo_q  <= ~addr[0];
          hi_q  <= byte_hi;
          idx_q <= addr[WB-1:1];
          st    <= hit ? S_DSWAIT : S_MISS;
        end
        S_DSWAIT: begin
          if (data_stb) begin
            wd_q <= wdata;
            cnt  <= CW'(WAIT_CLKS);
            st   <= S_BUSY;
          end else if (!addr_stb) begin
            st <= S_IDLE;
          end
        end
        S_BUSY: begin
          if (cnt == '0) begin
            if (wr_q) begin
              if (lo_q) mem[idx_q][7:0]  <= wd_q[7:0];
              if (hi_q) mem[idx_q][15:8] <= wd_q[15:8];
              ack <= 1'b1;
              st  <= S_ACK;
            end else begin
              rd_q  <= mem[idx_q];
              rd_oe <= 1'b1;
              st    <= S_DRIVE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DRIVE: begin
          ack <= 1'b1;
          st  <= S_ACK;
        end
        S_ACK: if (!addr_stb && !data_stb) begin
          ack   <= 1'b0;
          rd_oe <= 1'b0;
          st    <= S_IDLE;
        end
        S_MISS: if (!addr_stb) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_MISS |-> !ack && !rd_oe);
  assert_write_ack_after_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) && wr_q |-> $past(st) == S_BUSY);
  assert_read_data_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) && !wr_q |-> $past(rd_oe));
  assert_ack_with_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !wr_q |-> rd_oe);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !addr_stb && !data_stb |=> !ack && !rd_oe);
  assert_no_oe_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> !wr_q);
  assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack && (addr_stb || data_stb) |=> ack);
endmodule

// File: tb/sim_xbus_mem_slave.sv
`timescale 1ns/1ps
module sim_xbus_mem_slave;
  localparam logic [23:0] BASE = 24'h040000;
  localparam int WINB = 256;
  localparam int W = 2;
  localparam int WB = $clog2(WINB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_stb = 0, wr = 0, byte_hi = 0, data_stb = 0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic rd_oe, ack;
  int n_chk = 0, n_fail = 0;
  logic [15:0] model [WINB/2];

  always #5 clk = ~clk;

  xbus_mem_slave #(.BASE_ADDR(BASE), .WIN_BYTES(WINB), .WAIT_CLKS(W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr(addr), .wr(wr),
    .byte_hi(byte_hi), .data_stb(data_stb), .wdata(wdata), .rdata(rdata),
    .rd_oe(rd_oe), .ack(ack));

  function automatic bit is_hit(input logic [23:0] a);
    return a[23:WB] == BASE[23:WB];
  endfunction

  function automatic logic [15:0] merged(input logic [15:0] old, input logic [23:0] a,
                                         input bit h, input logic [15:0] d);
    logic [15:0] r = old;
    if (!a[0]) r[7:0] = d[7:0];
    if (h) r[15:8] = d[15:8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] a, input bit w, input bit h, input logic [15:0] d);
    int n = 0;
    bit oe_early = 0, oe_wr = 0, oe_at_ack = 0;
    logic [15:0] got = '0;
    @(negedge clk);
    addr = a; wr = w; byte_hi = h; wdata = d; addr_stb = 1;
    @(negedge clk);
    data_stb = 1;
    if (is_hit(a)) begin
      while (n < W + 10) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (n == 1) wdata = 16'($urandom);
        if (rd_oe && w) oe_wr = 1;
        if (!w && rd_oe && !ack) oe_early = 1;
        if (ack) begin oe_at_ack = rd_oe; got = rdata; break; end
      end
      if (w) begin
        chk(n == W + 2, "R3 write ack latency", n, W + 2);
        chk(!oe_wr, "R8 no output enable on write", oe_wr, 0);
        model[a[WB-1:1]] = merged(model[a[WB-1:1]], a, h, d);
      end else begin
        chk(n == W + 3, "R4 read ack latency", n, W + 3);
        chk(oe_early && oe_at_ack, "R4 enable before ack", {oe_early, oe_at_ack}, 3);
        chk(got == model[a[WB-1:1]], "R6 R5 read data", got, model[a[WB-1:1]]);
      end
      repeat (2) @(negedge clk);
      chk(ack == 1, "R9 ack held while strobes high", ack, 1);
    end else begin
      bit seen = 0;
      repeat (W + 6) begin
        @(negedge clk);
        if (ack || rd_oe) seen = 1;
      end
      chk(!seen, "R2 miss stays silent", seen, 0);
    end
    addr_stb = 0; data_stb = 0;
    @(negedge clk);
    chk(!ack && !rd_oe, "R7 release", {ack, rd_oe}, 0);
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < WINB/2; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(!ack && !rd_oe, "R1 reset outputs", {ack, rd_oe}, 0);
    rst_n = 1;
    xfer(BASE + 24'd10, 0, 1, 16'h0);
    xfer(BASE + 24'd20, 1, 1, 16'hA55A);
    xfer(BASE + 24'd20, 0, 1, 16'h0);
    xfer(BASE + 24'd20, 1, 0, 16'h1234);
    xfer(BASE + 24'd21, 1, 1, 16'hBE00);
    xfer(BASE + 24'd21, 1, 0, 16'hFFFF);
    xfer(BASE + 24'd20, 0, 1, 16'h0);
    xfer(BASE - 24'd1, 1, 1, 16'hDEAD);
    xfer(BASE + WINB, 0, 1, 16'h0);
    xfer(BASE + WINB - 1, 1, 1, 16'hC3C3);
    xfer(BASE + WINB - 2, 0, 1, 16'h0);
    for (int t = 0; t < 80; t++) begin
      logic [23:0] a;
      if ($urandom % 4 != 0) a = BASE + 24'($urandom % WINB);
      else a = {BASE[23:WB] ^ (16'($urandom % 255) + 16'd1), 8'($urandom)};
      xfer(a, bit'($urandom % 2), bit'($urandom % 2), 16'($urandom));
    end
    for (int i = 0; i < WINB; i += 2) xfer(BASE + 24'(i), 0, 1, 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule